// File: doc/BRIEF.md
# Counter-Tree Array Multiplier

This block multiplies two unsigned operands, 6 bits each by default, and returns the full double-width product. The design ANDs every multiplier bit with the multiplicand to form a matrix of partial products and arranges that matrix in bit columns. It then reduces each column with counters. Each counter outputs the binary count of the ones among its inputs. The count bits go to the same column and to the next two columns. The reduction stops when each column holds no more than two bits. A single carry-propagate adder then sums those two rows.

A compile-time parameter picks the reduction style. In one style the first level uses one wide counter (up to 7 inputs) per column, and a second level of 3-input counters finishes the job, so there are two levels in total. In the other style every level uses full adders (3 inputs) and passes leftover bits through, which takes three levels. The two styles give identical products. The result is captured in a single output register together with a valid flag.

Top module: `ctm_mult`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `product` shows the unsigned value `a * b` (2W bits, no truncation for W-bit operands) right after that edge.
- R2: Row i of the partial-product matrix is the multiplicand ANDed with multiplier bit i and weighted by 2^i. A multiplier with only bit i set therefore yields the multiplicand shifted left by i.
- R3: With `TREE_MODE` = 1, the first level reduces each column with counters of up to `BIG_N` inputs. Each counter outputs a 3-bit count whose bits 0, 1 and 2 go to columns k, k+1 and k+2. The reduction reaches two rows after two counter levels.
- R4: With `TREE_MODE` = 0, the columns are reduced by 3-input counters (full adders) in three levels, and the product is still `a * b`.
- R5: Both settings of `TREE_MODE` give bit-identical `product` values for every operand pair.
- R6: `out_valid` is high in the cycle right after a cycle in which `in_valid` was sampled high, and in no other cycle. It rises together with the new product.
- R7: When `in_valid` is sampled low, `product` keeps its previous value, whatever `a` and `b` carry.
- R8: A rising edge with `rst_n` low clears `out_valid` and `product` to zero. The reset is synchronous and active low.
- R9: The corner operands give the exact products: 0 × anything is 0, and all-ones × all-ones (63 × 63) is 3969.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands on `a` and `b` are to be multiplied |
| a | input | W | Multiplicand, unsigned |
| b | input | W | Multiplier, unsigned |
| out_valid | output | 1 | `product` was loaded at the last edge |
| product | output | 2W | Registered unsigned product |

## Verification
The product and its valid flag are due exactly one rising edge after the operands are presented with `in_valid` high, because the whole tree is combinational in front of the single output register. The bench drives each pair on a falling edge. It then waits through one rising edge and samples on the next falling edge, before it drives the following pair. Both tree styles run side by side on the same stimulus, so each pair is compared with `a*b` and across the two modes in the same cycle. The hold and reset checks sample one edge after the idle or reset cycle.

// File: rtl/ctm_pkg.sv
// Package ctm_pkg
// Elaboration-time helpers that size the column-reduction tree.
// Assumption: every column is padded to a uniform height per level. In each
// level a column of height H is split into floor(H/K) counters of K = min(N,H)
// inputs, and the leftover bits pass straight through to the next level.
package ctm_pkg;

    // Counter size used by level l for the chosen tree style.
    function automatic int level_n(int mode, int big_n, int l);
        return (mode == 1 && l == 0) ? big_n : 3;
    endfunction

    // Column height after one level with counters of up to n inputs.
    function automatic int next_h(int h, int n);
        int k;
        int nc;
        int rem;
        k   = (n < h) ? n : h;
        nc  = h / k;
        rem = h % k;
        return rem + nc * ((k > 3) ? 3 : 2);
    endfunction

    // Column height at the input of level l (l = 0 is the raw matrix).
    function automatic int level_h(int w, int mode, int big_n, int l);
        int h;
        h = w;
        for (int i = 0; i < 16; i++) begin
            if (i < l && h > 2) h = next_h(h, level_n(mode, big_n, i));
        end
        return h;
    endfunction

    // Number of levels needed until each column holds at most two bits.
    function automatic int num_levels(int w, int mode, int big_n);
        int h;
        int l;
        h = w;
        l = 0;
        for (int i = 0; i < 16; i++) begin
            if (h > 2) begin
                h = next_h(h, level_n(mode, big_n, i));
                l = l + 1;
            end
        end
        return l;
    endfunction

endpackage

// File: rtl/ctm_counter.sv
// Module ctm_counter
// Counts the ones among N input bits and returns the count as a 3-bit
// binary number {y2,y1,y0}.
// Assumption: N is 7 or less, so the count always fits in 3 bits.
module ctm_counter #(
    parameter int N = 7
) (
    input  logic [N-1:0] bits,
    output logic [2:0]   count
);

    // Population count of the input bits.
    always_comb begin
        count = 3'd0;
        for (int i = 0; i < N; i++) begin
            count = count + 3'(bits[i]);
        end
    end

endmodule

// File: rtl/ctm_pp.sv
// Module ctm_pp
// Builds the partial-product matrix. Slot i of column c holds a[c-i] & b[i],
// so row i is the multiplicand gated by multiplier bit i, weighted 2^i.
// Assumption: slots with no partial product are driven to zero (padding).
module ctm_pp #(
    parameter int W = 6,
    localparam int COLS = 2 * W
) (
    input  logic [W-1:0]                a,
    input  logic [W-1:0]                b,
    output logic [COLS-1:0][W-1:0]      cols
);

    // AND array laid out by column of weight.
    always_comb begin
        cols = '0;
        for (int c = 0; c < COLS; c++) begin
            for (int i = 0; i < W; i++) begin
                if (c - i >= 0 && c - i < W) cols[c][i] = a[c-i] & b[i];
            end
        end
    end

endmodule

// File: rtl/ctm_level.sv
// Module ctm_level
// One reduction level. Every column of height HIN is split into NC counters of
// K inputs. Count bit 0 stays in column c, and bit 1 (and bit 2 for counters
// wider than 3) moves to c+1 (c+2). The remaining REM bits pass through.
// Assumption: the output height fits in HMAX. Counts carried past the top
// column are dropped, which is exact for a product that fits in COLS bits.
module ctm_level #(
    parameter int COLS = 12,
    parameter int HMAX = 6,
    parameter int HIN  = 6,
    parameter int N    = 7
) (
    input  logic [COLS-1:0][HMAX-1:0] col_in,
    output logic [COLS-1:0][HMAX-1:0] col_out
);

    localparam int K    = (N < HIN) ? N : HIN;
    localparam int NC   = HIN / K;
    localparam int REM  = HIN % K;
    localparam int CW   = (K > 3) ? 3 : 2;

    logic [COLS-1:0][NC-1:0][2:0] cnt;
    logic                         lvl_unused;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar g = 0; g < NC; g++) begin : g_cnt
            ctm_counter #(.N(K)) u_cnt (
                .bits  (col_in[c][g*K +: K]),
                .count (cnt[c][g])
            );
        end
    end

    // Route counter bits by weight and pass leftover bits through.
    always_comb begin
        col_out = '0;
        for (int c = 0; c < COLS; c++) begin
            for (int g = 0; g < NC; g++) col_out[c][g] = cnt[c][g][0];
            for (int r = 0; r < REM; r++) col_out[c][NC+r] = col_in[c][NC*K+r];
        end
        for (int c = 1; c < COLS; c++) begin
            for (int g = 0; g < NC; g++) col_out[c][NC+REM+g] = cnt[c-1][g][1];
        end
        if (CW == 3) begin
            for (int c = 2; c < COLS; c++) begin
                for (int g = 0; g < NC; g++) col_out[c][2*NC+REM+g] = cnt[c-2][g][2];
            end
        end
    end

    // Dropped top-column counts and padding bits are intentionally unused.
    assign lvl_unused = ^{cnt, col_in};

endmodule

// File: rtl/ctm_mult.sv
// Module ctm_mult (top)
// Unsigned W x W multiplier built from partial products, a counter-based
// column-reduction tree and a final carry-propagate adder. The single output
// register loads the product when in_valid is sampled high.
// TREE_MODE = 1: wide BIG_N:3 counters, then 3-input counters (two levels).
// TREE_MODE = 0: full-adder levels only (three levels at W = 6).
// Assumption: the synchronous reset is active low. Operands are unsigned.
module ctm_mult #(
    parameter int W         = 6,
    parameter int TREE_MODE = 1,
    parameter int BIG_N     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    output logic              out_valid,
    output logic [2*W-1:0]    product
);

    localparam int COLS = 2 * W;
    localparam int NLEV = ctm_pkg::num_levels(W, TREE_MODE, BIG_N);
    localparam int HFIN = ctm_pkg::level_h(W, TREE_MODE, BIG_N, NLEV);

    logic [NLEV:0][COLS-1:0][W-1:0] stage;
    logic [COLS-1:0]                row0;
    logic [COLS-1:0]                row1;
    logic [COLS-1:0]                sum_rows;
    logic [COLS-1:0]                ref_prod;
    logic                           top_unused;

    ctm_pp #(.W(W)) u_pp (
        .a    (a),
        .b    (b),
        .cols (stage[0])
    );

    for (genvar l = 0; l < NLEV; l++) begin : g_lvl
        ctm_level #(
            .COLS (COLS),
            .HMAX (W),
            .HIN  (ctm_pkg::level_h(W, TREE_MODE, BIG_N, l)),
            .N    (ctm_pkg::level_n(TREE_MODE, BIG_N, l))
        ) u_lvl (
            .col_in  (stage[l]),
            .col_out (stage[l+1])
        );
    end

    // Pick the two surviving rows out of the last level.
    always_comb begin
        row0 = '0;
        row1 = '0;
        for (int c = 0; c < COLS; c++) begin
            row0[c] = stage[NLEV][c][0];
            if (HFIN > 1) row1[c] = stage[NLEV][c][1];
        end
    end

    // Final carry-propagate add.
    assign sum_rows   = row0 + row1;
    assign top_unused = ^stage;

    // Output register with valid flag; holds the product while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) product <= sum_rows;
        end
    end

    // Reference product for the checks only.
    assign ref_prod = COLS'(a) * COLS'(b);

    AST_ROWS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        sum_rows == ref_prod);                                              // R3
    AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> product == $past(ref_prod));                           // R1
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                            // R6
    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));                                     // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(product));                                    // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && product == '0));                          // R8

endmodule

// File: tb/ctm_mult_tb.sv
// Bench for ctm_mult: a vector table, an exhaustive sweep in both tree styles,
// then directed hold and reset tests.
module ctm_mult_tb;

    localparam int W    = 6;
    localparam int PW   = 2 * W;
    localparam int NVEC = 10;

    // Each entry is {a, b, expected product}.
    localparam logic [W+W+PW-1:0] VEC [NVEC] = '{
        {6'd0,  6'd0,  12'd0},
        {6'd63, 6'd63, 12'd3969},
        {6'd63, 6'd1,  12'd63},
        {6'd1,  6'd63, 12'd63},
        {6'd32, 6'd32, 12'd1024},
        {6'd42, 6'd42, 12'd1764},
        {6'd21, 6'd42, 12'd882},
        {6'd63, 6'd0,  12'd0},
        {6'd45, 6'd32, 12'd1440},
        {6'd45, 6'd4,  12'd180}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  a = '0;
    logic [W-1:0]  b = '0;
    logic          ov_c, ov_f;
    logic [PW-1:0] p_c, p_f;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    ctm_mult #(.W(W), .TREE_MODE(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
        .out_valid(ov_c), .product(p_c)
    );

    ctm_mult #(.W(W), .TREE_MODE(0)) u_dut_fa (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
        .out_valid(ov_f), .product(p_f)
    );

    task automatic check(string req, logic [PW-1:0] got, logic [PW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    // Drive one pair with valid high, then sample one edge later.
    task automatic apply(logic [W-1:0] va, logic [W-1:0] vb);
        a        = va;
        b        = vb;
        in_valid = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R8: reset state
        check("R8 reset out_valid", PW'(ov_c), '0);
        check("R8 reset product", p_c, '0);
        check("R8 reset product fa", p_f, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R1, R9, R2 (single-bit multipliers)
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][PW+W+W-1 -: W], VEC[i][PW+W-1 -: W]);
            check("R1 R9 table counter", p_c, VEC[i][PW-1:0]);
            check("R4 table full-adder", p_f, VEC[i][PW-1:0]);
        end
        for (int i = 0; i < W; i++) begin
            apply(6'd45, W'(1 << i));
            check("R2 row shift", p_c, PW'(45) << i);
        end

        // Exhaustive sweep: R3, R4, R5, R6
        for (int x = 0; x < (1 << W); x++) begin
            for (int y = 0; y < (1 << W); y++) begin
                apply(W'(x), W'(y));
                check("R3 counter tree", p_c, PW'(x * y));
                check("R4 adder tree", p_f, PW'(x * y));
                check("R5 modes equal", p_c, p_f);
                check("R6 out_valid", PW'(ov_c), PW'(1));
            end
        end

        // R6 / R7: idle cycles hold the product and drop out_valid
        apply(6'd7, 6'd9);
        check("R1 before hold", p_c, 12'd63);
        in_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            a = W'(10 + i);
            b = W'(50 - i);
            @(negedge clk);
            check("R7 hold counter", p_c, 12'd63);
            check("R7 hold full-adder", p_f, 12'd63);
            check("R6 idle out_valid", PW'(ov_c), '0);
        end

        // R8: reset in mid-run with valid high
        a        = 6'd63;
        b        = 6'd63;
        in_valid = 1'b1;
        rst_n    = 1'b0;
        @(negedge clk);
        check("R8 mid reset out_valid", PW'(ov_c), '0);
        check("R8 mid reset product", p_c, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 max after reset", p_c, 12'd3969);
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule